// File: doc/BRIEF.md
# Code-Period Integrator with Bit Boundary Tracking

This block sits behind the correlator of one tracking channel. Each time the correlator finishes a spreading-code period it raises an end-of-code strobe and presents six signed correlation values: early, prompt and late, each in phase and in quadrature. The block adds these values over a programmable number of code periods. When an interval closes, it releases the six totals to the loop estimator with a one-cycle integration pulse. It also tracks where the 20-code data bits begin and end. At each bit edge it sends a one-bit decision to the data decoder, taken from the sign of the prompt in-phase total over that bit.

A code counter holds the position of the current code inside its data bit. The counter advances on every end-of-code strobe and returns to zero at a bit edge. It is driven out so that a measurement snapshot can turn it into the code term of the transmit time. When the channel reaches bit synchronization, a load strobe writes an alignment offset into the counter and clears all partial sums. The next integration interval and the next bit are then counted from that phase.

Top module: `code_phase_integrator`

## Requirements
- R1: `code_cnt_o` moves from k to k+1 on each edge that samples `eoc_i` high, wraps from BIT_LEN-1 to 0, and otherwise holds. BIT_LEN defaults to 20.
- R2: `int_sel_i` sets the integration length L in code periods. The codes are 0→1, 1→2, 2→4, 3→5 and 4→10. Code 5 and every unused code (6, 7) select 20.
- R3: Suppose the edge that samples `eoc_i` high leaves the counter at a multiple of L. One clock edge later, `eoi_o` is high for one cycle. Each `*_sum_o` output then holds the sum of its input, sampled at every end-of-code of that interval. The outputs are ordered ie, ip, il, qe, qp and ql.
- R4: When an end-of-code wraps the counter to 0, `eob_o` pulses on the same cycle as that interval's `eoi_o`.
- R5: When `eob_o` is high, `bit_o` is 1 if the prompt in-phase total over the bit's end-of-code samples is zero or positive, and 0 if it is negative.
- R6: An end-of-code that arrives on the cycle the sums are dumped counts only toward the new interval, including when end-of-code strobes come back to back.
- R7: `sync_i` loads `sync_phase_i` into the counter (values above BIT_LEN-1 load BIT_LEN-1). It clears all partial sums and cancels any pending dump. An `eoc_i` on the same edge is ignored. The first interval and the first bit after the load are partial.
- R8: After reset the counter is 0, `eoi_o`, `eob_o` and `bit_o` are 0, and all sums read 0.
- R9: With no end-of-code, no pulse is emitted and the counter and the sums hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoc_i | input | 1 | End-of-code strobe from the correlator |
| sync_i | input | 1 | Load bit alignment and clear partial sums |
| sync_phase_i | input | CNT_W | Counter phase to load |
| int_sel_i | input | 3 | Integration length code |
| ie_i | input | CORR_W | Early in-phase correlation |
| ip_i | input | CORR_W | Prompt in-phase correlation |
| il_i | input | CORR_W | Late in-phase correlation |
| qe_i | input | CORR_W | Early quadrature correlation |
| qp_i | input | CORR_W | Prompt quadrature correlation |
| ql_i | input | CORR_W | Late quadrature correlation |
| code_cnt_o | output | CNT_W | Code index within the current bit |
| eoi_o | output | 1 | End-of-integration pulse |
| ie_sum_o | output | ACC_W | Integrated early in-phase |
| ip_sum_o | output | ACC_W | Integrated prompt in-phase |
| il_sum_o | output | ACC_W | Integrated late in-phase |
| qe_sum_o | output | ACC_W | Integrated early quadrature |
| qp_sum_o | output | ACC_W | Integrated prompt quadrature |
| ql_sum_o | output | ACC_W | Integrated late quadrature |
| eob_o | output | 1 | End-of-bit pulse |
| bit_o | output | 1 | Bit decision, valid with eob_o |

## Verification
A wrong counter phase shows up as a `code_cnt_o` value off by one on the cycle after the end-of-code that caused it. It also shifts the `eoi_o` and `eob_o` pulses, which throws the integration counts and the bit counts off by the end of a run. A sum that leaks across an interval boundary, or that drops the dump-cycle sample, appears in the very next `*_sum_o` value. The bench computes every interval total from a closed-form input pattern across all lengths and several load phases, so such an error is caught at the first dump.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  localparam int NUM_ARMS = 6;
  localparam int SEL_W    = 3;

  // Integration length in code periods; every entry divides a 20-code bit.
  function automatic logic [5:0] sel_to_len(input logic [SEL_W-1:0] sel);
    logic [5:0] len;
    case (sel)
      3'd0:    len = 6'd1;
      3'd1:    len = 6'd2;
      3'd2:    len = 6'd4;
      3'd3:    len = 6'd5;
      3'd4:    len = 6'd10;
      default: len = 6'd20;
    endcase
    return len;
  endfunction
endpackage

// File: rtl/cpi_phase_ctr.sv
module cpi_phase_ctr #(
  parameter int BIT_LEN = 20,
  parameter int CNT_W   = 5,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eoc,
  input  logic             sync,
  input  logic [CNT_W-1:0] phase,
  input  logic [LEN_W-1:0] int_len,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dump_pend_q,
  output logic             bit_pend_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_LEN - 1);

  logic [LEN_W-1:0] cnt_plus;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] phase_ld;
  logic             int_end;
  logic             bit_end;

  always_comb begin
    cnt_plus = LEN_W'(cnt_q) + LEN_W'(1);
    bit_end  = (cnt_q == LAST);
    cnt_nxt  = bit_end ? '0 : cnt_q + CNT_W'(1);
    int_end  = ((cnt_plus % int_len) == '0);
    phase_ld = (phase > LAST) ? LAST : phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      dump_pend_q <= 1'b0;
      bit_pend_q  <= 1'b0;
    end else if (sync) begin
      cnt_q       <= phase_ld;
      dump_pend_q <= 1'b0;
      bit_pend_q  <= 1'b0;
    end else begin
      dump_pend_q <= eoc && int_end;
      bit_pend_q  <= eoc && bit_end;
      if (eoc) cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/cpi_accum.sv
module cpi_accum #(
  parameter int IN_W  = 12,
  parameter int ACC_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add,
  input  logic             dump,
  input  logic [IN_W-1:0]  val,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] val_x;
  assign val_x = {{(ACC_W-IN_W){val[IN_W-1]}}, val};

  always_ff @(posedge clk) begin
    if (rst || clr)  acc_q <= '0;
    else if (dump)   acc_q <= add ? val_x : '0;
    else if (add)    acc_q <= acc_q + val_x;
  end
endmodule

// File: rtl/cpi_dump_stage.sv
module cpi_dump_stage #(
  parameter int ARMS  = 6,
  parameter int ACC_W = 17
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       dump_pend,
  input  logic                       bit_pend,
  input  logic [ARMS-1:0][ACC_W-1:0] acc_all,
  input  logic [ACC_W-1:0]           bit_acc,
  output logic [ARMS-1:0][ACC_W-1:0] sum_q,
  output logic                       eoi_q,
  output logic                       eob_q,
  output logic                       bit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      eoi_q <= 1'b0;
      eob_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      eoi_q <= dump_pend && !clr;
      eob_q <= bit_pend && !clr;
      if (bit_pend && !clr) bit_q <= ~bit_acc[ACC_W-1];
    end
  end

  for (genvar a = 0; a < ARMS; a++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)                    sum_q[a] <= '0;
      else if (dump_pend && !clr) sum_q[a] <= acc_all[a];
    end
  end
endmodule

// File: rtl/code_phase_integrator.sv
module code_phase_integrator
  import cpi_pkg::*;
#(
  parameter int  CORR_W  = 12,
  parameter int  BIT_LEN = 20,
  localparam int CNT_W   = $clog2(BIT_LEN),
  localparam int ACC_W   = CORR_W + $clog2(BIT_LEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     eoc_i,
  input  logic                     sync_i,
  input  logic [CNT_W-1:0]         sync_phase_i,
  input  logic [SEL_W-1:0]         int_sel_i,
  input  logic signed [CORR_W-1:0] ie_i,
  input  logic signed [CORR_W-1:0] ip_i,
  input  logic signed [CORR_W-1:0] il_i,
  input  logic signed [CORR_W-1:0] qe_i,
  input  logic signed [CORR_W-1:0] qp_i,
  input  logic signed [CORR_W-1:0] ql_i,
  output logic [CNT_W-1:0]         code_cnt_o,
  output logic                     eoi_o,
  output logic signed [ACC_W-1:0]  ie_sum_o,
  output logic signed [ACC_W-1:0]  ip_sum_o,
  output logic signed [ACC_W-1:0]  il_sum_o,
  output logic signed [ACC_W-1:0]  qe_sum_o,
  output logic signed [ACC_W-1:0]  qp_sum_o,
  output logic signed [ACC_W-1:0]  ql_sum_o,
  output logic                     eob_o,
  output logic                     bit_o
);
  localparam int LEN_W = CNT_W + 1;

  logic [NUM_ARMS-1:0][CORR_W-1:0] arm_in;
  logic [NUM_ARMS-1:0][ACC_W-1:0]  arm_acc;
  logic [NUM_ARMS-1:0][ACC_W-1:0]  arm_sum;
  logic [ACC_W-1:0]                bit_acc;
  logic [LEN_W-1:0]                int_len;
  logic                            dump_pend;
  logic                            bit_pend;

  assign arm_in  = {ql_i, qp_i, qe_i, il_i, ip_i, ie_i};
  assign int_len = LEN_W'(sel_to_len(int_sel_i));

  cpi_phase_ctr #(.BIT_LEN(BIT_LEN), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst(rst), .eoc(eoc_i), .sync(sync_i), .phase(sync_phase_i),
    .int_len(int_len), .cnt_q(code_cnt_o), .dump_pend_q(dump_pend),
    .bit_pend_q(bit_pend)
  );

  for (genvar a = 0; a < NUM_ARMS; a++) begin : g_arm
    cpi_accum #(.IN_W(CORR_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .clr(sync_i), .add(eoc_i && !sync_i),
      .dump(dump_pend), .val(arm_in[a]), .acc_q(arm_acc[a])
    );
  end

  // Bit-long prompt in-phase total, dumped on the bit boundary only.
  cpi_accum #(.IN_W(CORR_W), .ACC_W(ACC_W)) u_bit_acc (
    .clk(clk), .rst(rst), .clr(sync_i), .add(eoc_i && !sync_i),
    .dump(bit_pend), .val(ip_i), .acc_q(bit_acc)
  );

  cpi_dump_stage #(.ARMS(NUM_ARMS), .ACC_W(ACC_W)) u_out (
    .clk(clk), .rst(rst), .clr(sync_i), .dump_pend(dump_pend),
    .bit_pend(bit_pend), .acc_all(arm_acc), .bit_acc(bit_acc),
    .sum_q(arm_sum), .eoi_q(eoi_o), .eob_q(eob_o), .bit_q(bit_o)
  );

  assign ie_sum_o = arm_sum[0];
  assign ip_sum_o = arm_sum[1];
  assign il_sum_o = arm_sum[2];
  assign qe_sum_o = arm_sum[3];
  assign qp_sum_o = arm_sum[4];
  assign ql_sum_o = arm_sum[5];
endmodule

// File: rtl/cpi_checker.sv
module cpi_checker #(
  parameter int BIT_LEN = 20,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             eoc_i,
  input logic             sync_i,
  input logic [CNT_W-1:0] sync_phase_i,
  input logic [CNT_W-1:0] code_cnt_o,
  input logic             eoi_o,
  input logic             eob_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_LEN - 1);

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    code_cnt_o <= LAST);

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
    (eoc_i && !sync_i) |=> code_cnt_o ==
      (($past(code_cnt_o) == LAST) ? CNT_W'(0) : $past(code_cnt_o) + CNT_W'(1)));

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!eoc_i && !sync_i) |=> $stable(code_cnt_o));

  p_eoi_after_eoc_r3: assert property (@(posedge clk) disable iff (rst)
    eoi_o |-> $past(eoc_i, 2));

  p_eob_with_eoi_r4: assert property (@(posedge clk) disable iff (rst)
    eob_o |-> eoi_o);

  p_eob_wrapped_r4: assert property (@(posedge clk) disable iff (rst)
    eob_o |-> $past(code_cnt_o) == CNT_W'(0));

  p_sync_load_r7: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> code_cnt_o ==
      (($past(sync_phase_i) > LAST) ? LAST : $past(sync_phase_i)));
endmodule

bind code_phase_integrator cpi_checker #(.BIT_LEN(BIT_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .eoc_i(eoc_i), .sync_i(sync_i),
  .sync_phase_i(sync_phase_i), .code_cnt_o(code_cnt_o),
  .eoi_o(eoi_o), .eob_o(eob_o)
);

// File: tb/sim_code_phase_integrator.sv
module sim_code_phase_integrator;
  localparam int CW = 12;
  localparam int BL = 20;
  localparam int NW = $clog2(BL);
  localparam int AW = CW + $clog2(BL + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, eoc = 1'b0, sync = 1'b0;
  logic [NW-1:0] phase = '0;
  logic [2:0] sel = '0;
  logic signed [CW-1:0] ie = '0, ip = '0, il = '0, qe = '0, qp = '0, ql = '0;
  logic [NW-1:0] code_cnt;
  logic eoi, eob, bitv;
  logic signed [AW-1:0] s_ie, s_ip, s_il, s_qe, s_qp, s_ql;

  code_phase_integrator #(.CORR_W(CW), .BIT_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .eoc_i(eoc), .sync_i(sync), .sync_phase_i(phase),
    .int_sel_i(sel), .ie_i(ie), .ip_i(ip), .il_i(il), .qe_i(qe), .qp_i(qp),
    .ql_i(ql), .code_cnt_o(code_cnt), .eoi_o(eoi), .ie_sum_o(s_ie),
    .ip_sum_o(s_ip), .il_sum_o(s_il), .qe_sum_o(s_qe), .qp_sum_o(s_qp),
    .ql_sum_o(s_ql), .eob_o(eob), .bit_o(bitv)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0, mon_on = 1'b0, b2b = 1'b0;
  int cur_p = 0, cur_l = 1, cur_seed = 0, eoi_idx = 0, eob_idx = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R2 encoding: 0->1, 1->2, 2->4, 3->5, 4->10, others->20
  function automatic int len_of(int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 5;
      4: return 10;
      default: return 20;
    endcase
  endfunction

  // Arm order: 0 ie, 1 ip, 2 il, 3 qe, 4 qp, 5 ql
  function automatic int vval(int i, int ch, int seed, int p);
    int b;
    if (seed == 99) return 0;
    b = ((i * (ch + 3) + seed * 5 + ch * 11) % 37) - 18;
    if (ch == 1) b += ((((i + p) / BL) + seed) % 2 == 1) ? 9 : -9;
    return b;
  endfunction

  function automatic int exp_sum(int ch, int idx);
    int e, st, s;
    e  = (cur_p / cur_l + 1) * cur_l + idx * cur_l;
    st = (e - cur_l < cur_p) ? cur_p : e - cur_l;
    s  = 0;
    for (int g = st; g < e; g++) s += vval(g - cur_p, ch, cur_seed, cur_p);
    return s;
  endfunction

  function automatic int exp_bit(int idx);
    int e, st, s;
    e  = (cur_p / BL + 1) * BL + idx * BL;
    st = (e - BL < cur_p) ? cur_p : e - BL;
    s  = 0;
    for (int g = st; g < e; g++) s += vval(g - cur_p, 1, cur_seed, cur_p);
    return (s >= 0) ? 1 : 0;
  endfunction

  always @(negedge clk) begin
    if (mon_on && eoi) begin
      chk(b2b ? "R6" : "R3", "ie sum", int'(s_ie), exp_sum(0, eoi_idx));
      chk(b2b ? "R6" : "R3", "ip sum", int'(s_ip), exp_sum(1, eoi_idx));
      chk(b2b ? "R6" : "R3", "il sum", int'(s_il), exp_sum(2, eoi_idx));
      chk(b2b ? "R6" : "R3", "qe sum", int'(s_qe), exp_sum(3, eoi_idx));
      chk(b2b ? "R6" : "R3", "qp sum", int'(s_qp), exp_sum(4, eoi_idx));
      chk(b2b ? "R6" : "R3", "ql sum", int'(s_ql), exp_sum(5, eoi_idx));
      eoi_idx++;
    end
    if (mon_on && eob) begin
      chk("R4", "eob without eoi", int'(eoi), 1);
      chk("R5", "bit value", int'(bitv), exp_bit(eob_idx));
      eob_idx++;
    end
  end

  task automatic drive_vals(int i);
    ie = CW'(vval(i, 0, cur_seed, cur_p));
    ip = CW'(vval(i, 1, cur_seed, cur_p));
    il = CW'(vval(i, 2, cur_seed, cur_p));
    qe = CW'(vval(i, 3, cur_seed, cur_p));
    qp = CW'(vval(i, 4, cur_seed, cur_p));
    ql = CW'(vval(i, 5, cur_seed, cur_p));
  endtask

  task automatic do_sync(int p, int s, int seed, bit with_eoc);
    @(posedge clk); #1;
    sync = 1'b1; phase = NW'(p); sel = 3'(s); eoc = with_eoc;
    ie = 12'sd55; ip = 12'sd55; il = 12'sd55; qe = 12'sd55; qp = 12'sd55; ql = 12'sd55;
    cur_p = (p > BL - 1) ? BL - 1 : p;
    cur_l = len_of(s); cur_seed = seed; eoi_idx = 0; eob_idx = 0;
    @(posedge clk); #1;
    sync = 1'b0; eoc = 1'b0;
    @(negedge clk);
    chk("R7", "phase after load", int'(code_cnt), cur_p);
  endtask

  task automatic run(int n, bit all_b2b);
    int gap;
    b2b = all_b2b;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      eoc = 1'b1;
      drive_vals(i);
      gap = (all_b2b || i % 4 == 0) ? 0 : i % 3;
      repeat (gap) begin @(posedge clk); #1; eoc = 1'b0; end
    end
    @(posedge clk); #1; eoc = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3", "dump count", eoi_idx, (cur_p + n) / cur_l - cur_p / cur_l);
    chk("R4", "bit count", eob_idx, (cur_p + n) / BL - cur_p / BL);
    chk("R1", "final counter", int'(code_cnt), (cur_p + n) % BL);
    b2b = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ph[4];
    int snap[7];
    ph = '{0, 1, 5, 19};
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8", "counter", int'(code_cnt), 0);
    chk("R8", "eoi", int'(eoi), 0);
    chk("R8", "eob", int'(eob), 0);
    chk("R8", "bit", int'(bitv), 0);
    chk("R8", "ie sum", int'(s_ie), 0);
    chk("R8", "ql sum", int'(s_ql), 0);
    mon_on = 1'b1;

    // R2/R3/R7: every length against several load phases
    for (int s = 0; s < 6; s++)
      for (int k = 0; k < 4; k++) begin
        do_sync(ph[k], s, s * 4 + k, k == 2);
        run(47, 1'b0);
      end

    // R2: unused select code gives 20; R7: phase above range is clamped
    do_sync(31, 7, 7, 1'b0);
    run(45, 1'b0);

    // R6: strobes every cycle with single-code intervals and two-code intervals
    do_sync(0, 0, 11, 1'b0);
    run(43, 1'b1);
    do_sync(3, 1, 12, 1'b1);
    run(41, 1'b1);

    // R5: zero total over a bit decides 1
    do_sync(0, 5, 99, 1'b0);
    run(40, 1'b0);

    // R7: a load right after an interval-closing strobe cancels the dump
    do_sync(0, 0, 3, 1'b0);
    @(posedge clk); #1; eoc = 1'b1; drive_vals(0);
    @(posedge clk); #1; eoc = 1'b0; sync = 1'b1; phase = NW'(4);
    cur_p = 4; eoi_idx = 0; eob_idx = 0;
    @(posedge clk); #1; sync = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", "cancelled dump count", eoi_idx, 0);
    chk("R7", "counter after cancel", int'(code_cnt), 4);

    // R9: idle inputs with changing data leave everything unchanged
    snap = '{int'(s_ie), int'(s_ip), int'(s_il), int'(s_qe), int'(s_qp), int'(s_ql), int'(code_cnt)};
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1; drive_vals(i + 100);
    end
    @(negedge clk);
    chk("R9", "pulses while idle", eoi_idx + eob_idx, 0);
    chk("R9", "ie hold", int'(s_ie), snap[0]);
    chk("R9", "ip hold", int'(s_ip), snap[1]);
    chk("R9", "il hold", int'(s_il), snap[2]);
    chk("R9", "qe hold", int'(s_qe), snap[3]);
    chk("R9", "qp hold", int'(s_qp), snap[4]);
    chk("R9", "ql hold", int'(s_ql), snap[5]);
    chk("R9", "counter hold", int'(code_cnt), snap[6]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule